// File: doc/BRIEF.md
# Control Transfer Stage Tracker

This block follows a USB control transfer on the peripheral side. It starts at the SETUP packet and ends with the status handshake. The current stage is reported as a fixed 3-bit code. The block does not parse packets. It takes decoded single-cycle event strobes instead:

- a SETUP arrival, qualified by its direction bit and by whether its length field is nonzero;
- IN tokens addressed to endpoint 0;
- OUT tokens addressed to endpoint 0;
- completion of a status handshake.

Each cycle, the block picks the next stage from the current stage and these events. It registers that stage and raises a one-cycle change pulse whenever the reported code differs from the code of the previous cycle. That pulse is meant to set the control-stage-change status flag elsewhere in the chip.

A token that goes against the expected flow moves the block to a dedicated sequence-error code. The code is only meaningful while the block works in peripheral role. Outside that role, the tracker is held at the idle code.

Stage codes:

| Code | Stage |
|------|-------|
| 000 | idle or setup |
| 001 | read transfer, data stage |
| 010 | read transfer, status stage |
| 011 | write transfer, data stage |
| 100 | write transfer, status stage |
| 101 | status stage of a write that has no data stage |
| 110 | sequence error |
| 111 | reserved, never output |

Top module: `ctrlStageTracker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `stageCode` is 000 and `stageChange` is 0.
- R2: In peripheral role, a SETUP event leads to a new code on the next clock, from any stage. The new code is 001 if `setupDirIn` is 1. It is 011 if `setupDirIn` is 0 and `setupLenNonZero` is 1. It is 101 if both are 0. Tokens and `statusAck` in the same cycle are ignored.
- R3: In stage 001, an OUT token moves the stage to 010, and an IN token keeps it at 001.
- R4: In stage 011, an IN token moves the stage to 100, and an OUT token keeps it at 011.
- R5: In a status stage (010, 100 or 101), `statusAck` with no token in the same cycle returns the stage to 000. The stage's own status token (OUT for 010, IN for 100 and 101) keeps the stage unchanged, even if `statusAck` is also high.
- R6: Two cases move the stage to 110. The first is a data-direction token in a status stage: IN in 010, or OUT in 100 or 101. The second is IN and OUT tokens in the same cycle in any stage from 001 to 101.
- R7: Stage 110 is left only by a SETUP event or by leaving peripheral role. Tokens and `statusAck` there leave the code unchanged.
- R8: In stage 000, tokens and `statusAck` have no effect. In data stages (001, 011), `statusAck` has no effect.
- R9: While `periphMode` is 0, the stage becomes 000 on the next clock and all events are ignored.
- R10: `stageChange` is high for exactly the cycles in which `stageCode` differs from its value in the previous cycle. `stageCode` never shows 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periphMode | input | 1 | 1 when the controller works in peripheral role |
| setupValid | input | 1 | SETUP packet received (one-cycle strobe) |
| setupDirIn | input | 1 | SETUP direction: 1 means device-to-host |
| setupLenNonZero | input | 1 | SETUP length field is nonzero |
| ep0InToken | input | 1 | IN token for endpoint 0 (strobe) |
| ep0OutToken | input | 1 | OUT token for endpoint 0 (strobe) |
| statusAck | input | 1 | Status-stage handshake completed (strobe) |
| stageCode | output | 3 | Current control stage code |
| stageChange | output | 1 | One-cycle pulse when `stageCode` changes |

## Verification
The bench targets the following corner cases:

- **Same-code SETUP.** A SETUP that re-enters the code already shown must give no change pulse. A design that pulses on every load instead of every change would flag a spurious status event.
- **SETUP against tokens.** A SETUP arriving together with tokens, or in the error stage, must win. A design with the wrong priority would stay stuck in error, or take the token's transition.
- **Status handshake timing.** `statusAck` in a data stage or together with a status token must be ignored. A design that got this wrong would end a transfer early.
- **Role loss and wrong-direction tokens.** Dropping peripheral role mid-transfer must return the stage to idle. Wrong-direction and simultaneous tokens must reach the error code, which a lax decoder would keep in a normal stage.

// File: rtl/ctrl_stage_pkg.sv
`timescale 1ns/1ps
package ctrl_stage_pkg;

  localparam int STAGE_W = 3;

  typedef enum logic [STAGE_W-1:0] {
    STG_IDLE      = 3'b000,
    STG_RD_DATA   = 3'b001,
    STG_RD_STAT   = 3'b010,
    STG_WR_DATA   = 3'b011,
    STG_WR_STAT   = 3'b100,
    STG_WR_NODATA = 3'b101,
    STG_SEQ_ERR   = 3'b110
  } stage_e;

  // strobes from the control decision to the stage register
  typedef struct packed {
    logic   load;
    stage_e code;
  } stage_strobe_t;

endpackage

// File: rtl/ctrlStageCtl.sv
`timescale 1ns/1ps
module ctrlStageCtl
  import ctrl_stage_pkg::*;
(
  input  stage_e        curStage,
  input  logic          periphMode,
  input  logic          setupValid,
  input  logic          setupDirIn,
  input  logic          setupLenNonZero,
  input  logic          ep0InToken,
  input  logic          ep0OutToken,
  input  logic          statusAck,
  output stage_strobe_t strobe
);

  logic bothTok;
  stage_e setupTarget;

  assign bothTok = ep0InToken & ep0OutToken;

  always_comb begin
    if (setupDirIn)           setupTarget = STG_RD_DATA;
    else if (setupLenNonZero) setupTarget = STG_WR_DATA;
    else                      setupTarget = STG_WR_NODATA;
  end

  always_comb begin
    strobe.load = 1'b0;
    strobe.code = STG_IDLE;
    if (!periphMode) begin
      strobe.load = 1'b1;
      strobe.code = STG_IDLE;
    end else if (setupValid) begin
      strobe.load = 1'b1;
      strobe.code = setupTarget;
    end else begin
      unique case (curStage)
        STG_RD_DATA: begin
          if (bothTok) begin
            strobe.load = 1'b1; strobe.code = STG_SEQ_ERR;
          end else if (ep0OutToken) begin
            strobe.load = 1'b1; strobe.code = STG_RD_STAT;
          end
        end
        STG_WR_DATA: begin
          if (bothTok) begin
            strobe.load = 1'b1; strobe.code = STG_SEQ_ERR;
          end else if (ep0InToken) begin
            strobe.load = 1'b1; strobe.code = STG_WR_STAT;
          end
        end
        STG_RD_STAT: begin
          if (ep0InToken) begin
            strobe.load = 1'b1; strobe.code = STG_SEQ_ERR;
          end else if (!ep0OutToken && statusAck) begin
            strobe.load = 1'b1; strobe.code = STG_IDLE;
          end
        end
        STG_WR_STAT, STG_WR_NODATA: begin
          if (ep0OutToken) begin
            strobe.load = 1'b1; strobe.code = STG_SEQ_ERR;
          end else if (!ep0InToken && statusAck) begin
            strobe.load = 1'b1; strobe.code = STG_IDLE;
          end
        end
        default: begin
          strobe.load = 1'b0;
          strobe.code = STG_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/ctrlStageRegs.sv
`timescale 1ns/1ps
module ctrlStageRegs
  import ctrl_stage_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  stage_strobe_t strobe,
  output stage_e        curStage,
  output logic          changePulse
);

  stage_e stageQ;
  logic   changeQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stageQ  <= STG_IDLE;
      changeQ <= 1'b0;
    end else begin
      changeQ <= strobe.load && (strobe.code != stageQ);
      if (strobe.load) stageQ <= strobe.code;
    end
  end

  assign curStage    = stageQ;
  assign changePulse = changeQ;

endmodule

// File: rtl/ctrlStageTracker.sv
`timescale 1ns/1ps
module ctrlStageTracker
  import ctrl_stage_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               periphMode,
  input  logic               setupValid,
  input  logic               setupDirIn,
  input  logic               setupLenNonZero,
  input  logic               ep0InToken,
  input  logic               ep0OutToken,
  input  logic               statusAck,
  output logic [STAGE_W-1:0] stageCode,
  output logic               stageChange
);

  stage_e        curStage;
  stage_strobe_t strobe;

  ctrlStageCtl ctl_i (
    .curStage        (curStage),
    .periphMode      (periphMode),
    .setupValid      (setupValid),
    .setupDirIn      (setupDirIn),
    .setupLenNonZero (setupLenNonZero),
    .ep0InToken      (ep0InToken),
    .ep0OutToken     (ep0OutToken),
    .statusAck       (statusAck),
    .strobe          (strobe)
  );

  ctrlStageRegs regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .curStage    (curStage),
    .changePulse (stageChange)
  );

  assign stageCode = curStage;

endmodule

// File: rtl/ctrlStageTracker_chk.sv
`timescale 1ns/1ps
module ctrlStageTracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       periphMode,
  input logic       setupValid,
  input logic       setupDirIn,
  input logic       setupLenNonZero,
  input logic       ep0InToken,
  input logic       ep0OutToken,
  input logic       statusAck,
  input logic [2:0] stageCode,
  input logic       stageChange
);

  logic inStatus;
  assign inStatus = (stageCode == 3'b010) || (stageCode == 3'b100) || (stageCode == 3'b101);

  // R10
  no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stageCode != 3'b111);

  // R10
  change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stageChange == (stageCode != $past(stageCode)));

  // R2
  setup_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periphMode && setupValid && setupDirIn |=> stageCode == 3'b001);

  // R2
  setup_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periphMode && setupValid && !setupDirIn && !setupLenNonZero |=> stageCode == 3'b101);

  // R9
  role_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !periphMode |=> stageCode == 3'b000);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periphMode && !setupValid && stageCode == 3'b110 |=> stageCode == 3'b110);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periphMode && !setupValid && stageCode == 3'b000 |=> stageCode == 3'b000);

  // R5
  status_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periphMode && !setupValid && inStatus && statusAck && !ep0InToken && !ep0OutToken
    |=> stageCode == 3'b000);

  // R6
  dual_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periphMode && !setupValid && ep0InToken && ep0OutToken
    && stageCode != 3'b000 && stageCode != 3'b110 |=> stageCode == 3'b110);

  // R3
  read_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periphMode && !setupValid && stageCode == 3'b001 && ep0OutToken && !ep0InToken
    |=> stageCode == 3'b010);

  // R4
  write_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periphMode && !setupValid && stageCode == 3'b011 && ep0InToken && !ep0OutToken
    |=> stageCode == 3'b100);

endmodule

bind ctrlStageTracker ctrlStageTracker_chk chk_i (.*);

// File: tb/ctrlStageTracker_tb_top.sv
`timescale 1ns/1ps
module ctrlStageTracker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       periphMode = 1'b0;
  logic       setupValid = 1'b0;
  logic       setupDirIn = 1'b0;
  logic       setupLenNonZero = 1'b0;
  logic       ep0InToken = 1'b0;
  logic       ep0OutToken = 1'b0;
  logic       statusAck = 1'b0;
  logic [2:0] stageCode;
  logic       stageChange;

  int         testsRun = 0;
  int         testsFailed = 0;
  logic [2:0] expStage = 3'b000;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  ctrlStageTracker dut_i (
    .clk(clk), .rst_n(rst_n), .periphMode(periphMode), .setupValid(setupValid),
    .setupDirIn(setupDirIn), .setupLenNonZero(setupLenNonZero),
    .ep0InToken(ep0InToken), .ep0OutToken(ep0OutToken), .statusAck(statusAck),
    .stageCode(stageCode), .stageChange(stageChange)
  );

  function automatic logic [2:0] refNext(input logic [2:0] cur, input logic pm,
      input logic sv, input logic sd, input logic sl, input logic ti,
      input logic to, input logic ack);
    logic rd, stat, dataTok, statTok;
    if (!pm) return 3'b000;
    if (sv) return sd ? 3'b001 : (sl ? 3'b011 : 3'b101);
    if (cur == 3'b000 || cur == 3'b110) return cur;
    if (ti && to) return 3'b110;
    rd      = (cur == 3'b001) || (cur == 3'b010);
    stat    = (cur == 3'b010) || (cur == 3'b100) || (cur == 3'b101);
    dataTok = rd ? ti : to;
    statTok = rd ? to : ti;
    if (!stat) return statTok ? (rd ? 3'b010 : 3'b100) : cur;
    if (dataTok) return 3'b110;
    if (statTok) return cur;
    return ack ? 3'b000 : cur;
  endfunction

  function automatic string refTag(input logic [2:0] cur, input logic pm, input logic sv,
      input logic ti, input logic to);
    if (!pm) return "R9";
    if (sv) return "R2";
    if (cur == 3'b110) return "R7";
    if (cur == 3'b000) return "R8";
    if (ti && to) return "R6";
    if (cur == 3'b001) return "R3";
    if (cur == 3'b011) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive at negedge, evaluate after next posedge, at the following negedge
  task automatic step(input logic pm, input logic sv, input logic sd, input logic sl,
                      input logic ti, input logic to, input logic ack);
    logic [2:0] nxt;
    string tag;
    periphMode = pm; setupValid = sv; setupDirIn = sd; setupLenNonZero = sl;
    ep0InToken = ti; ep0OutToken = to; statusAck = ack;
    nxt = refNext(expStage, pm, sv, sd, sl, ti, to, ack);
    tag = refTag(expStage, pm, sv, ti, to);
    @(posedge clk);
    @(negedge clk);
    check(tag, "stageCode", int'(stageCode), int'(nxt));
    check("R10", "stageChange", int'(stageChange), int'(nxt != expStage));
    expStage = nxt;
  endtask

  task automatic idleCycle();
    step(1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C71));
    repeat (3) @(negedge clk);
    check("R1", "stageCode in reset", int'(stageCode), 0);
    check("R1", "stageChange in reset", int'(stageChange), 0);
    periphMode = 1'b1;
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "stageCode after reset", int'(stageCode), 0);
    check("R1", "stageChange after reset", int'(stageChange), 0);

    // R8 idle ignores tokens and ack
    step(1, 0, 0, 0, 1, 0, 1);
    step(1, 0, 0, 0, 0, 1, 0);
    // R2/R3/R5 read flow
    step(1, 1, 1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 1, 0, 1);   // IN + ack in data stage: no effect
    step(1, 0, 0, 0, 0, 1, 0);   // to read status
    step(1, 0, 0, 0, 0, 1, 1);   // status token with ack holds
    step(1, 0, 0, 0, 0, 0, 1);   // back to idle
    // R2/R4/R5 write flow
    step(1, 1, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 1);
    // R2 no-data write, R6 wrong-direction status token, R7 error hold
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 1, 1, 1);
    step(1, 0, 0, 0, 0, 0, 1);
    // R2 setup wins over tokens, leaves error
    step(1, 1, 1, 0, 1, 1, 1);
    // R10 same-code setup gives no pulse
    step(1, 1, 1, 1, 0, 0, 0);
    // R6 dual tokens in data stage
    step(1, 0, 0, 0, 1, 1, 0);
    // R9 role loss, events ignored while off
    step(1, 1, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 1, 1, 0, 0, 1, 1);
    idleCycle();

    // constrained random mixture
    for (int i = 0; i < 4000; i++) begin
      logic pm, sv, sd, sl, ti, to, ack;
      pm  = ($urandom_range(99) >= 3);
      sv  = ($urandom_range(99) < 8);
      sd  = $urandom_range(1);
      sl  = $urandom_range(1);
      ti  = ($urandom_range(99) < 25);
      to  = ($urandom_range(99) < 25);
      ack = ($urandom_range(99) < 20);
      step(pm, sv, sd, sl, ti, to, ack);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule